// File: doc/BRIEF.md
# Microwave Oven Cooking Timer

This block is the timing core of a microwave oven front panel. It holds a four-digit minutes:seconds value and shows it on four seven-segment digits. The user sets it from a 16-bit BCD preset and starts a countdown, which drives the cook relay. When the count runs out, the block writes a fixed completion message onto the display and drops the relay. A lamp-test request lights every segment so that a broken segment can be spotted.

Inside, a five-state controller decides what happens each cycle. A source selector picks which 16-bit value, if any, is written into the digits. A chain of four BCD down-counting digits holds the time. Counting advances once per `sec_tick` pulse while cooking. The pulse comes from a one-second prescaler outside the block. Button inputs are expected to arrive already debounced.

Top module: `mwo_cook_timer`

## Requirements
- R1: An asynchronous active-high `rst` puts the controller into its idle state and clears all four digits to 00:00. While reset is held and after its release, `cook` is low.
- R2: In idle, `lamp_test_req` wins over `set_req`, and `set_req` wins over `start_req`. When more than one is high in the same cycle, only the winning action takes place.
- R3: A lamp-test request writes 8 into every digit. A set request writes `preset` into the digits. `preset[15:12]` is minute tens, `[11:8]` minute units, `[7:4]` second tens and `[3:0]` second units. Each of these actions leaves the controller busy for one further cycle, during which requests are ignored, and then returns it to idle.
- R4: `cook` is high in the idle cycle where a start is accepted. It stays high on every following cycle while the time has not expired. It is low in all other cycles.
- R5: The displayed time falls by exactly one second on each rising clock edge where `cook` and `sec_tick` are both high. At no other edge does it change, except through a load. Units digits borrow from 0 to 9. Tens digits borrow from 0 to 5.
- R6: The time is expired when the digits read 00:00. A countdown stops at 00:00 and never wraps. On the first cycle after reaching 00:00 while cooking, `cook` drops and the completion code d-o-n-E is written into the digits (code 0xD, 0xB, 0xC, 0xE from minute tens to second units).
- R7: A start request is refused while the digits read 00:00 or show the completion code. In that case `cook` stays low and the display does not change.
- R8: Segment outputs are active high, with bit 0 = segment a through bit 6 = segment g. The digit patterns are: 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F, 9=0x6F. The completion letters are d=0x5E, o=0x5C, n=0x54, E=0x79.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| lamp_test_req | input | 1 | Request to light all segments |
| set_req | input | 1 | Request to load the preset time |
| start_req | input | 1 | Request to start cooking |
| preset | input | 16 | BCD time mm:ss, minute tens in the top nibble |
| sec_tick | input | 1 | One-cycle pulse per second |
| cook | output | 1 | Relay drive, high while cooking |
| seg_min_hi | output | 7 | Segments of the minute tens digit |
| seg_min_lo | output | 7 | Segments of the minute units digit |
| seg_sec_hi | output | 7 | Segments of the second tens digit |
| seg_sec_lo | output | 7 | Segments of the second units digit |

## Verification
The assertions assume two things about the inputs. First, `preset` is valid BCD no larger than 59:59. Second, a countdown starts only from such a value, never from the 88:88 lamp pattern. The random stimulus therefore draws each preset digit within its own range. It also raises `start_req` only when the current digits form a legal time, and it biases presets toward small values so that expiry and the completion message occur often. Request lines are driven with all combinations, including simultaneous ones, because the controller is expected to resolve them by priority.

// File: rtl/mwo_pkg.sv
package mwo_pkg;
  localparam int DIGIT_W  = 4;
  localparam int NUM_DIG  = 4;
  localparam int SEG_W    = 7;
  localparam int DATA_W   = DIGIT_W * NUM_DIG;
  localparam int UNIT_MOD = 10;
  localparam int TENS_MOD = 6;

  localparam logic [DATA_W-1:0] LAMP_CODE = 16'h8888;
  localparam logic [DATA_W-1:0] DONE_CODE = 16'hDBCE;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LAMP, ST_SET, ST_RUN, ST_MSG
  } ctl_state_t;

  // one step down with wrap at the digit's modulus
  function automatic logic [DIGIT_W-1:0] digit_dec(input logic [DIGIT_W-1:0] d,
                                                   input int modulus);
    if (d == '0) return DIGIT_W'(modulus - 1);
    return d - DIGIT_W'(1);
  endfunction

  // active-high segments, bit0 = a ... bit6 = g
  function automatic logic [SEG_W-1:0] seg_of(input logic [DIGIT_W-1:0] d);
    case (d)
      4'h0: return 7'h3F;
      4'h1: return 7'h06;
      4'h2: return 7'h5B;
      4'h3: return 7'h4F;
      4'h4: return 7'h66;
      4'h5: return 7'h6D;
      4'h6: return 7'h7D;
      4'h7: return 7'h07;
      4'h8: return 7'h7F;
      4'h9: return 7'h6F;
      4'hB: return 7'h5C;
      4'hC: return 7'h54;
      4'hD: return 7'h5E;
      4'hE: return 7'h79;
      default: return 7'h00;
    endcase
  endfunction
endpackage

// File: rtl/mwo_ctrl.sv
module mwo_ctrl
  import mwo_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic test_req,
  input  logic set_req,
  input  logic start_req,
  input  logic expired,
  output logic cook,
  output logic ld_lamp,
  output logic ld_user,
  output logic ld_msg
);
  ctl_state_t state, nxt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  always_comb begin
    nxt     = ST_IDLE;
    cook    = 1'b0;
    ld_lamp = 1'b0;
    ld_user = 1'b0;
    ld_msg  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (test_req) begin
          nxt = ST_LAMP; ld_lamp = 1'b1;
        end else if (set_req) begin
          nxt = ST_SET; ld_user = 1'b1;
        end else if (start_req && !expired) begin
          nxt = ST_RUN; cook = 1'b1;
        end
      end
      ST_LAMP: ld_lamp = 1'b1;
      ST_SET:  ld_user = 1'b1;
      ST_MSG:  ld_msg  = 1'b1;
      ST_RUN: begin
        if (expired) begin
          nxt = ST_MSG; ld_msg = 1'b1;
        end else begin
          nxt = ST_RUN; cook = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  // R3: at most one load source at a time
  a_r3_strobe_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld_lamp, ld_user, ld_msg}));

  // R3: the load states last a single cycle
  a_r3_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LAMP || state == ST_SET || state == ST_MSG) |=> state == ST_IDLE);

  // R6: expiry while running leads to the message state
  a_r6_to_msg: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && expired) |=> state == ST_MSG);

  // R4: cook always leads into the running state
  a_r4_cook_run: assert property (@(posedge clk) disable iff (rst)
    cook |=> state == ST_RUN);

  // R7: no start from an expired display
  a_r7_refuse: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && expired) |-> !cook);
endmodule

// File: rtl/mwo_load_sel.sv
module mwo_load_sel
  import mwo_pkg::*;
(
  input  logic              ld_lamp,
  input  logic              ld_user,
  input  logic              ld_msg,
  input  logic [DATA_W-1:0] user_val,
  output logic              load,
  output logic [DATA_W-1:0] load_val
);
  always_comb begin
    load = ld_lamp | ld_user | ld_msg;
    if (ld_lamp)     load_val = LAMP_CODE;
    else if (ld_msg) load_val = DONE_CODE;
    else             load_val = user_val;
  end
endmodule

// File: rtl/mwo_bcd_digit.sv
module mwo_bcd_digit
  import mwo_pkg::*;
#(
  parameter int MODULUS = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [DIGIT_W-1:0] load_d,
  input  logic               dec_en,
  output logic [DIGIT_W-1:0] q
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst)         q <= '0;
    else if (load)   q <= load_d;
    else if (dec_en) q <= digit_dec(q, MODULUS);
  end
endmodule

// File: rtl/mwo_cook_timer.sv
module mwo_cook_timer
  import mwo_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              lamp_test_req,
  input  logic              set_req,
  input  logic              start_req,
  input  logic [DATA_W-1:0] preset,
  input  logic              sec_tick,
  output logic              cook,
  output logic [SEG_W-1:0]  seg_min_hi,
  output logic [SEG_W-1:0]  seg_min_lo,
  output logic [SEG_W-1:0]  seg_sec_hi,
  output logic [SEG_W-1:0]  seg_sec_lo
);
  logic              ld_lamp, ld_user, ld_msg;
  logic              load;
  logic [DATA_W-1:0] load_val;
  logic [DATA_W-1:0] value;
  logic              expired;
  logic              step;
  logic [NUM_DIG-1:0] borrow;

  assign expired = (value == '0) || (value == DONE_CODE);
  assign step    = cook & sec_tick & ~expired;

  mwo_ctrl i_ctrl (
    .clk(clk), .rst(rst),
    .test_req(lamp_test_req), .set_req(set_req), .start_req(start_req),
    .expired(expired),
    .cook(cook), .ld_lamp(ld_lamp), .ld_user(ld_user), .ld_msg(ld_msg)
  );

  mwo_load_sel i_sel (
    .ld_lamp(ld_lamp), .ld_user(ld_user), .ld_msg(ld_msg),
    .user_val(preset), .load(load), .load_val(load_val)
  );

  // digit 0 = second units ... digit 3 = minute tens
  for (genvar g = 0; g < NUM_DIG; g++) begin : g_dig
    localparam int MODV = (g % 2 == 0) ? UNIT_MOD : TENS_MOD;
    if (g == 0) begin : g_first
      assign borrow[g] = step;
    end else begin : g_rest
      assign borrow[g] = borrow[g-1] & (value[(g-1)*DIGIT_W +: DIGIT_W] == '0);
    end
    mwo_bcd_digit #(.MODULUS(MODV)) i_digit (
      .clk(clk), .rst(rst), .load(load),
      .load_d(load_val[g*DIGIT_W +: DIGIT_W]),
      .dec_en(borrow[g]),
      .q(value[g*DIGIT_W +: DIGIT_W])
    );
  end

  assign seg_sec_lo = seg_of(value[0*DIGIT_W +: DIGIT_W]);
  assign seg_sec_hi = seg_of(value[1*DIGIT_W +: DIGIT_W]);
  assign seg_min_lo = seg_of(value[2*DIGIT_W +: DIGIT_W]);
  assign seg_min_hi = seg_of(value[3*DIGIT_W +: DIGIT_W]);

  // R5: without a counting edge or a load the time does not move
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!(cook && sec_tick) && !load) |=> $stable(value));

  // R5: a counting edge changes the time
  a_r5_step: assert property (@(posedge clk) disable iff (rst)
    (cook && sec_tick && !expired && !load) |=> value != $past(value));

  // R6: 00:00 is held until something is loaded
  a_r6_hold_zero: assert property (@(posedge clk) disable iff (rst)
    (value == '0 && !load) |=> value == '0);

  // R3: a load takes the selected source on the next edge
  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    load |=> value == $past(load_val));
endmodule

// File: tb/test_mwo_cook_timer.sv
module test_mwo_cook_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lamp_test_req = 1'b0, set_req = 1'b0, start_req = 1'b0, sec_tick = 1'b0;
  logic [15:0] preset = 16'h0;
  logic        cook;
  logic [6:0]  seg_min_hi, seg_min_lo, seg_sec_hi, seg_sec_lo;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // model: state 0 idle,1 lamp,2 set,3 run,4 msg ; md[0]=sec units..md[3]=min tens
  int ms;
  int md[4];

  always #5 clk = ~clk;

  mwo_cook_timer i_mwo_cook_timer (
    .clk(clk), .rst(rst), .lamp_test_req(lamp_test_req), .set_req(set_req),
    .start_req(start_req), .preset(preset), .sec_tick(sec_tick), .cook(cook),
    .seg_min_hi(seg_min_hi), .seg_min_lo(seg_min_lo),
    .seg_sec_hi(seg_sec_hi), .seg_sec_lo(seg_sec_lo)
  );

  function automatic logic [6:0] seg_exp(input int d);
    logic [6:0] t[16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                          7'h7F, 7'h6F, 7'h00, 7'h5C, 7'h54, 7'h5E, 7'h79, 7'h00};
    return t[d];
  endfunction

  function automatic logic [27:0] disp_of(input int a3, a2, a1, a0);
    return {seg_exp(a3), seg_exp(a2), seg_exp(a1), seg_exp(a0)};
  endfunction

  function automatic logic [27:0] model_disp();
    return disp_of(md[3], md[2], md[1], md[0]);
  endfunction

  function automatic bit model_expired();
    return (md[3] == 0 && md[2] == 0 && md[1] == 0 && md[0] == 0) ||
           (md[3] == 13 && md[2] == 11 && md[1] == 12 && md[0] == 14);
  endfunction

  function automatic bit model_legal();
    return md[3] <= 5 && md[2] <= 9 && md[1] <= 5 && md[0] <= 9;
  endfunction

  task automatic set_digits(input logic [15:0] v);
    md[3] = int'(v[15:12]); md[2] = int'(v[11:8]);
    md[1] = int'(v[7:4]);   md[0] = int'(v[3:0]);
  endtask

  task automatic check(input string tag, input logic [27:0] act, input logic [27:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [27:0] dut_disp();
    return {seg_min_hi, seg_min_lo, seg_sec_hi, seg_sec_lo};
  endfunction

  // one clock cycle, checked against the model
  task automatic cyc(input bit t, input bit s, input bit st, input bit tk, input logic [15:0] pv);
    bit mc, l8, lu, lm;
    int nx, tot;
    @(negedge clk);
    lamp_test_req = t; set_req = s; start_req = st; sec_tick = tk; preset = pv;
    #1;
    mc = 0; l8 = 0; lu = 0; lm = 0; nx = 0;
    case (ms)
      0: if (t) begin nx = 1; l8 = 1; end
         else if (s) begin nx = 2; lu = 1; end
         else if (st && !model_expired()) begin nx = 3; mc = 1; end
      1: l8 = 1;
      2: lu = 1;
      4: lm = 1;
      3: if (model_expired()) begin nx = 4; lm = 1; end
         else begin nx = 3; mc = 1; end
      default: nx = 0;
    endcase
    check("R4 cook", {27'd0, cook}, {27'd0, mc});
    @(posedge clk);
    ms = nx;
    if (l8) set_digits(16'h8888);
    else if (lm) set_digits(16'hDBCE);
    else if (lu) set_digits(pv);
    else if (mc && tk && !model_expired()) begin
      tot = (md[3] * 10 + md[2]) * 60 + md[1] * 10 + md[0] - 1;
      md[3] = tot / 600; md[2] = (tot / 60) % 10;
      md[1] = (tot % 60) / 10; md[0] = tot % 10;
    end
    #1;
    check("R5/R8 display", dut_disp(), model_disp());
  endtask

  function automatic logic [15:0] rand_preset();
    logic [15:0] v;
    if ($urandom_range(1, 0) == 1)
      v = {4'd0, 4'd0, 4'($urandom_range(1, 0)), 4'($urandom_range(9, 0))};
    else
      v = {4'($urandom_range(5, 0)), 4'($urandom_range(9, 0)),
           4'($urandom_range(5, 0)), 4'($urandom_range(9, 0))};
    return v;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    ms = 0; md = '{0, 0, 0, 0};
    #12;
    check("R1 reset display", dut_disp(), disp_of(0, 0, 0, 0));
    check("R1 reset cook", {27'd0, cook}, 28'd0);
    @(negedge clk); rst = 1'b0;

    // R7: start refused at 00:00
    cyc(0, 0, 1, 1, 16'h0);
    check("R7 refused at zero", dut_disp(), disp_of(0, 0, 0, 0));
    // R2: all requests together, lamp test wins
    cyc(1, 1, 1, 1, 16'h1234);
    check("R2 test priority", dut_disp(), disp_of(8, 8, 8, 8));
    // R3: request during the busy lamp cycle is ignored
    cyc(0, 1, 0, 0, 16'h4321);
    check("R3 busy cycle ignores set", dut_disp(), disp_of(8, 8, 8, 8));
    // R2: set beats start
    cyc(0, 1, 1, 1, 16'h1000);
    check("R3 preset loaded", dut_disp(), disp_of(1, 0, 0, 0));
    cyc(0, 0, 0, 0, 16'h1000);
    // R5: borrow across every digit
    cyc(0, 0, 1, 1, 16'h0);
    check("R5 10:00 to 09:59", dut_disp(), disp_of(0, 9, 5, 9));
    cyc(0, 0, 0, 0, 16'h0);
    check("R5 no tick no step", dut_disp(), disp_of(0, 9, 5, 9));
    // reset mid run
    @(negedge clk); rst = 1'b1; #1;
    check("R1 async reset", dut_disp(), disp_of(0, 0, 0, 0));
    ms = 0; md = '{0, 0, 0, 0};
    @(negedge clk); rst = 1'b0;
    // R6: run out and show the message
    cyc(0, 1, 0, 0, 16'h0001);
    cyc(0, 0, 0, 0, 16'h0001);
    cyc(0, 0, 1, 1, 16'h0);
    check("R6 reached zero", dut_disp(), disp_of(0, 0, 0, 0));
    cyc(0, 0, 0, 1, 16'h0);
    check("R6 completion code", dut_disp(), disp_of(13, 11, 12, 14));
    check("R6 cook off", {27'd0, cook}, 28'd0);
    cyc(0, 0, 0, 0, 16'h0);
    cyc(0, 0, 1, 1, 16'h0);
    check("R7 refused on message", dut_disp(), disp_of(13, 11, 12, 14));
    check("R8 letter d", {21'd0, seg_min_hi}, {21'd0, 7'h5E});

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit t, s, st, tk;
      t  = ($urandom_range(99, 0) < 2);
      s  = ($urandom_range(99, 0) < 5);
      st = ($urandom_range(99, 0) < 12) && (ms != 0 || model_legal());
      if (ms == 0 && !model_legal() && !t && !s) st = 0;
      tk = ($urandom_range(99, 0) < 40);
      cyc(t, s, st, tk, rand_preset());
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule